// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division over many clock cycles and keeps its results in a private pair of result registers, HI and LO. A request carries two operands, a flag that selects multiply or divide, and a flag that selects signed or unsigned arithmetic. A multiply leaves the upper half of the double-width product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI.

Software-visible moves out of the pair go through one read port. The port has a request, a select and a one-cycle valid strobe. A read that arrives while an operation is in flight is parked and is answered only once the new result has landed, so a consumer never sees a stale value.

Signed operations work on magnitudes. The sign of each result is applied after the last iteration. Both operations share one iteration counter and one set of shift registers.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0, and reads of HI and LO both return 0.
- R2: An unsigned multiply (`is_div`=0, `is_signed`=0) leaves bits [63:32] of the 64-bit product in HI and bits [31:0] in LO.
- R3: A signed multiply (`is_div`=0, `is_signed`=1) treats both operands as two's complement and leaves the 64-bit two's-complement product split the same way, including the most-negative-times-most-negative case.
- R4: An unsigned divide (`is_div`=1, `is_signed`=0) with a nonzero divisor leaves the quotient in LO and the remainder in HI, and the remainder is smaller than the divisor.
- R5: A signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend. The most-negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: A divide by zero raises nothing and gives a fixed result. LO is all ones and HI equals the dividend, except that a signed divide of a negative dividend gives LO = 1 and HI = the dividend.
- R7: A `start` seen while idle raises `busy` from the next cycle. `busy` stays high for exactly WIDTH cycles, and the result is in HI/LO when it falls.
- R8: A `start` seen while `busy` is high is ignored, and HI/LO end up holding the result of the operation already running.
- R9: While idle, a one-cycle `rd_req` gives `rd_valid` high for one cycle in the next cycle. `rd_data` is then HI when `rd_sel`=1 and LO when `rd_sel`=0.
- R10: A `rd_req` seen while `busy` is high produces no `rd_valid` until `busy` has fallen. It then returns the newly written value of the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation request, taken only while idle |
| is_div | input | 1 | 1 = divide, 0 = multiply |
| is_signed | input | 1 | 1 = two's-complement operands |
| opa | input | WIDTH | Multiplicand or dividend |
| opb | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| rd_req | input | 1 | Read request for HI or LO |
| rd_sel | input | 1 | 1 = HI, 0 = LO |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | WIDTH | Value of the selected register |

## Verification
The bench builds the unit with its default WIDTH of 32. At that width, operands such as 0x80000000 and 0xFFFFFFFF exercise the sign-fixing step at both extremes, and the bench's own 64-bit arithmetic yields the expected HI and LO without any overflow of its own. The busy window is a full 32 iterations at this width. That leaves room to inject a second start and a parked read at points well inside an operation and to show that neither disturbs the result.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic {
    PICK_LO = 1'b0,
    PICK_HI = 1'b1
  } pick_e;

endpackage

// File: rtl/mdu_mul_step.sv
module mdu_mul_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc_hi,
  input  logic [WIDTH-1:0] acc_lo,
  input  logic [WIDTH-1:0] mcand,
  output logic [WIDTH-1:0] nxt_hi,
  output logic [WIDTH-1:0] nxt_lo
);
  logic [WIDTH:0] partial;

  // add the multiplicand when the current multiplier bit is set, then shift right
  always_comb begin
    partial = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mcand} : '0);
    nxt_hi  = partial[WIDTH:1];
    nxt_lo  = {partial[0], acc_lo[WIDTH-1:1]};
  end
endmodule

// File: rtl/mdu_div_step.sv
module mdu_div_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem,
  input  logic [WIDTH-1:0] quo,
  input  logic [WIDTH-1:0] dvsr,
  output logic [WIDTH-1:0] nxt_rem,
  output logic [WIDTH-1:0] nxt_quo
);
  logic [WIDTH:0] shifted;
  logic [WIDTH:0] trial;
  logic           fits;

  // restoring step: shift one dividend bit in, keep the difference if non-negative
  always_comb begin
    shifted = {rem, quo[WIDTH-1]};
    trial   = shifted - {1'b0, dvsr};
    fits    = (shifted >= {1'b0, dvsr});
    nxt_rem = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
    nxt_quo = {quo[WIDTH-2:0], fits};
  end
endmodule

// File: rtl/mdu_read_port.sv
module mdu_read_port #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             rd_req,
  input  logic             rd_sel,
  input  logic [WIDTH-1:0] hi_val,
  input  logic [WIDTH-1:0] lo_val,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  import muldiv_pkg::*;

  logic  parked_q;
  pick_e parked_sel_q;
  pick_e use_sel;
  logic  want;

  assign want    = rd_req | parked_q;
  assign use_sel = rd_req ? pick_e'(rd_sel) : parked_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked_q     <= 1'b0;
      parked_sel_q <= PICK_LO;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
    end else if (want && !busy) begin
      parked_q <= 1'b0;
      rd_valid <= 1'b1;
      rd_data  <= (use_sel == PICK_HI) ? hi_val : lo_val;
    end else begin
      rd_valid <= 1'b0;
      if (rd_req) begin
        parked_q     <= 1'b1;
        parked_sel_q <= pick_e'(rd_sel);
      end
    end
  end

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(busy)); // R10
  AST_PARKED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (parked_q && !busy) |=> rd_valid); // R10
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy) |=> rd_valid); // R9
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_div,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             busy,
  input  logic             rd_req,
  input  logic             rd_sel,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v, input logic sgn);
    return (sgn && v[WIDTH-1]) ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [WIDTH-1:0] flip1(input logic [WIDTH-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [2*WIDTH-1:0] flip2(input logic [2*WIDTH-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic             busy_q, div_q, neg_main_q, neg_rem_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] acc_hi_q, acc_lo_q, opb_q, hi_q, lo_q;
  logic [WIDTH-1:0] mul_hi, mul_lo, div_rem, div_quo, step_hi, step_lo;
  logic [2*WIDTH-1:0] signed_prod;
  logic             accept, commit;

  assign accept = start && !busy_q;
  assign commit = busy_q && (cnt_q == LAST);
  assign busy   = busy_q;

  mdu_mul_step #(.WIDTH(WIDTH)) u_mul (
    .acc_hi(acc_hi_q), .acc_lo(acc_lo_q), .mcand(opb_q),
    .nxt_hi(mul_hi), .nxt_lo(mul_lo)
  );

  mdu_div_step #(.WIDTH(WIDTH)) u_div (
    .rem(acc_hi_q), .quo(acc_lo_q), .dvsr(opb_q),
    .nxt_rem(div_rem), .nxt_quo(div_quo)
  );

  assign step_hi     = div_q ? div_rem : mul_hi;
  assign step_lo     = div_q ? div_quo : mul_lo;
  assign signed_prod = flip2({mul_hi, mul_lo}, neg_main_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      div_q      <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      cnt_q      <= '0;
      acc_hi_q   <= '0;
      acc_lo_q   <= '0;
      opb_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      div_q      <= is_div;
      neg_main_q <= is_signed && (opa[WIDTH-1] ^ opb[WIDTH-1]);
      neg_rem_q  <= is_signed && opa[WIDTH-1];
      cnt_q      <= '0;
      acc_hi_q   <= '0;
      acc_lo_q   <= magnitude(opa, is_signed);
      opb_q      <= magnitude(opb, is_signed);
    end else if (busy_q) begin
      acc_hi_q <= step_hi;
      acc_lo_q <= step_lo;
      cnt_q    <= cnt_q + 1'b1;
      if (commit) begin
        busy_q <= 1'b0;
        if (div_q) begin
          lo_q <= flip1(div_quo, neg_main_q);
          hi_q <= flip1(div_rem, neg_rem_q);
        end else begin
          hi_q <= signed_prod[2*WIDTH-1:WIDTH];
          lo_q <= signed_prod[WIDTH-1:0];
        end
      end
    end
  end

  mdu_read_port #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .busy(busy_q), .rd_req(rd_req), .rd_sel(rd_sel),
    .hi_val(hi_q), .lo_val(lo_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R7
  AST_COMMIT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy); // R7
  AST_RESULT_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(hi_q) && $stable(lo_q))); // R8
  AST_REMAINDER_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && div_q && (opb_q != '0)) |-> (div_rem < opb_q)); // R4
endmodule

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_div = 1'b0, is_signed = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic busy, rd_req = 1'b0, rd_sel = 1'b0, rd_valid;
  logic [W-1:0] rd_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  muldiv_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_div(is_div), .is_signed(is_signed),
    .opa(opa), .opb(opb), .busy(busy), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {is_div, is_signed, a, b}
  localparam logic [65:0] VECS [10] = '{
    {1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {1'b0, 1'b0, 32'h12345678, 32'h9ABCDEF0},
    {1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000001},
    {1'b0, 1'b1, 32'h80000000, 32'h80000000},
    {1'b0, 1'b1, 32'hFFFFFFF9, 32'h00000003},
    {1'b1, 1'b0, 32'd100,      32'd7},
    {1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000010},
    {1'b1, 1'b1, 32'hFFFFFFF9, 32'h00000002},
    {1'b1, 1'b1, 32'h00000007, 32'hFFFFFFFE},
    {1'b1, 1'b1, 32'h80000000, 32'hFFFFFFFF}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic d, input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] hi, output logic [W-1:0] lo);
    longint sa, sb, p, q, r;
    logic [63:0] up;
    sa = s ? longint'($signed(a)) : longint'({32'b0, a});
    sb = s ? longint'($signed(b)) : longint'({32'b0, b});
    if (!d) begin
      if (s) p = sa * sb;
      else begin up = {32'b0, a} * {32'b0, b}; p = longint'(up); end
      hi = p[63:32];
      lo = p[31:0];
    end else begin
      q = sa / sb;
      r = sa % sb;
      lo = q[31:0];
      hi = r[31:0];
    end
  endtask

  task automatic run_op(input logic d, input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                        output int cycles);
    @(negedge clk);
    start = 1'b1; is_div = d; is_signed = s; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (busy && cycles < 1000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic sel, output logic [W-1:0] d, output logic ok);
    @(negedge clk);
    rd_req = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_req = 1'b0;
    ok = rd_valid;
    d = rd_data;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] eh, el, got;
    logic ok;
    int cyc;
    int waited;
    logic seen_busy;

    repeat (3) @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    rd(1'b1, got, ok);
    chk("R1 HI after reset", got, 32'd0);
    chk("R9 valid idle read", {31'b0, ok}, 32'd1);
    rd(1'b0, got, ok);
    chk("R1 LO after reset", got, 32'd0);
    @(negedge clk);
    chk("R9 valid one cycle", {31'b0, rd_valid}, 32'd0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < 10; i++) begin
      model(VECS[i][65], VECS[i][64], VECS[i][63:32], VECS[i][31:0], eh, el);
      run_op(VECS[i][65], VECS[i][64], VECS[i][63:32], VECS[i][31:0], cyc);
      if (i == 0) chk("R7 busy cycles", cyc, W);
      rd(1'b1, got, ok);
      chk(VECS[i][65] ? (VECS[i][64] ? "R5 HI" : "R4 HI") : (VECS[i][64] ? "R3 HI" : "R2 HI"), got, eh);
      rd(1'b0, got, ok);
      chk(VECS[i][65] ? (VECS[i][64] ? "R5 LO" : "R4 LO") : (VECS[i][64] ? "R3 LO" : "R2 LO"), got, el);
    end

    // R6 divide by zero
    run_op(1'b1, 1'b0, 32'h00ABCDEF, 32'd0, cyc);
    rd(1'b0, got, ok); chk("R6 unsigned LO", got, 32'hFFFFFFFF);
    rd(1'b1, got, ok); chk("R6 unsigned HI", got, 32'h00ABCDEF);
    run_op(1'b1, 1'b1, 32'hFFFFFF00, 32'd0, cyc);
    rd(1'b0, got, ok); chk("R6 signed neg LO", got, 32'h00000001);
    rd(1'b1, got, ok); chk("R6 signed neg HI", got, 32'hFFFFFF00);
    run_op(1'b1, 1'b1, 32'h00000055, 32'd0, cyc);
    rd(1'b0, got, ok); chk("R6 signed pos LO", got, 32'hFFFFFFFF);

    // R8 start while busy ignored
    @(negedge clk);
    start = 1'b1; is_div = 1'b0; is_signed = 1'b0; opa = 32'd1000; opb = 32'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; is_div = 1'b1; opa = 32'd9; opb = 32'd2;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (busy && waited < 1000) begin waited++; @(negedge clk); end
    chk("R8 busy window unchanged", waited, W - 6);
    rd(1'b0, got, ok); chk("R8 LO first op", got, 32'd3000);
    rd(1'b1, got, ok); chk("R8 HI first op", got, 32'd0);

    // R10 read parked while busy
    @(negedge clk);
    start = 1'b1; is_div = 1'b0; is_signed = 1'b1; opa = 32'hFFFFFFFE; opb = 32'h40000000;
    @(negedge clk);
    start = 1'b0; rd_req = 1'b1; rd_sel = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    waited = 0;
    seen_busy = 1'b0;
    while (!rd_valid && waited < 1000) begin
      waited++;
      @(negedge clk);
    end
    seen_busy = busy;
    chk("R10 busy low at valid", {31'b0, seen_busy}, 32'd0);
    chk("R10 waited past busy", {31'b0, (waited >= W - 2)}, 32'd1);
    chk("R10 parked HI value", rd_data, 32'hFFFFFFFF);
    rd(1'b0, got, ok); chk("R10 LO after", got, 32'h80000000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule